// File: doc/BRIEF.md
# Boundary-Ordered Synchronous FIFO

This block is a single-clock first-in first-out queue with a guarded write side and a guarded read side. Each side has an enable and a ready. An operation takes effect in a cycle only when its enable and its ready are both high. A build-time mode parameter picks how the queue orders a write and a read that arrive in the same cycle while it is completely full or completely empty. Away from those two states, every mode takes both operations in one cycle.

There are three modes:
- **Strict** refuses the write when full and the read when empty, whatever the other side does.
- **Drain-first** treats a same-cycle read as having already freed a slot, so a full queue takes a write while it is being read.
- **Pass-through** treats a same-cycle write as having already arrived, so an empty queue hands that word straight to the reader without storing it.

The ready outputs already include the mode's rule for the current cycle, so a client can start an operation from ready alone. Storage is a circular buffer with read and write pointers and an occupancy count. Depth and word width are parameters.

Top module: `bsem_fifo`

## Requirements
- R1: After reset the queue is empty. With both enables low, the write ready is 1 and the read ready is 0 in every mode.
- R2: Words leave in the order they were accepted. When a read is performed on a non-empty queue, the read data in that cycle is the oldest stored word.
- R3: When occupancy is between 1 and DEPTH-1, a cycle with both enables high performs both operations, and occupancy is unchanged afterwards.
- R4: In strict mode (mode code 0), write ready is 0 when the queue holds DEPTH words, and read ready is 0 when it holds none, whatever the other enable is.
- R5: In drain-first mode (mode code 1), a full queue raises write ready in any cycle where the read enable is high. A write and a read together then remove the oldest word and store the new one, and the queue stays full.
- R6: In drain-first mode, read ready is 0 while the queue is empty.
- R7: In pass-through mode (mode code 2), an empty queue drives read ready equal to the write enable. A same-cycle write and read returns the written word on the read data in that cycle, and the word is not stored: the queue is still empty in the next cycle.
- R8: In pass-through mode, write ready is 0 while the queue is full, even when the read enable is high.
- R9: An enable raised while its ready is low has no effect. No word is taken or lost, and occupancy changes only through the operations actually performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; empties the queue |
| enq_en | input | 1 | Write request |
| enq_data | input | WIDTH | Word to write |
| enq_rdy | output | 1 | A write is accepted this cycle if requested |
| deq_en | input | 1 | Read request |
| deq_data | output | WIDTH | Oldest word, or the incoming word during pass-through |
| deq_rdy | output | 1 | A read is performed this cycle if requested |

## Verification
The hardest case to reach is a full queue that receives a write and a read in the same cycle. This matters most in drain-first mode, where write ready depends combinationally on the read enable and the pointers then move together at the wrap point. The stimulus alternates between phases weighted toward writing, toward reading, and balanced traffic, so all three instances repeatedly sit at full and at empty while both enables toggle. A directed cycle at the start puts a simultaneous write and read on an empty queue, so pass-through is exercised before any word has ever been stored.

// File: rtl/bsem_fifo_pkg.sv
package bsem_fifo_pkg;

  typedef enum logic [1:0] {
    SEM_STRICT = 2'd0,
    SEM_DRAIN  = 2'd1,
    SEM_PASS   = 2'd2
  } sem_mode_e;

  // occupancy after one cycle, given whether a word was stored and whether one was removed
  function automatic int unsigned occ_after(int unsigned occ, logic stored, logic removed);
    int unsigned r;
    r = occ;
    if (stored) r = r + 1;
    if (removed) r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/bsem_fifo_gate.sv
module bsem_fifo_gate
  import bsem_fifo_pkg::*;
#(
  parameter sem_mode_e MODE = SEM_DRAIN
) (
  input  logic full,
  input  logic empty,
  input  logic enq_en,
  input  logic deq_en,
  output logic enq_rdy,
  output logic deq_rdy,
  output logic enq_fire,
  output logic deq_fire,
  output logic pass_thru
);

  always_comb begin
    unique case (MODE)
      SEM_DRAIN: begin
        enq_rdy = !full || deq_en;
        deq_rdy = !empty;
      end
      SEM_PASS: begin
        enq_rdy = !full;
        deq_rdy = !empty || enq_en;
      end
      default: begin
        enq_rdy = !full;
        deq_rdy = !empty;
      end
    endcase
  end

  assign enq_fire  = enq_en && enq_rdy;
  assign deq_fire  = deq_en && deq_rdy;
  assign pass_thru = (MODE == SEM_PASS) && empty && enq_fire && deq_fire;

endmodule

// File: rtl/bsem_fifo_ptrs.sv
module bsem_fifo_ptrs
  import bsem_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (wr) tail_q <= step(tail_q);
      if (rd) head_q <= step(head_q);
      occ_q <= CW'(occ_after(int'(occ_q), wr, rd));
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign occ   = occ_q;
  assign full  = (occ_q == CW'(DEPTH));
  assign empty = (occ_q == '0);

endmodule

// File: rtl/bsem_fifo_store.sv
module bsem_fifo_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PW'(i))) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/bsem_fifo.sv
module bsem_fifo
  import bsem_fifo_pkg::*;
#(
  parameter int        DEPTH = 4,
  parameter int        WIDTH = 8,
  parameter sem_mode_e MODE  = SEM_DRAIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_en,
  input  logic [WIDTH-1:0] enq_data,
  output logic             enq_rdy,
  input  logic             deq_en,
  output logic [WIDTH-1:0] deq_data,
  output logic             deq_rdy
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          full, empty;
  logic          enq_fire, deq_fire, pass_thru;
  logic          wr, rd;
  logic [PW-1:0] head, tail;
  logic [CW-1:0] occ;
  logic [WIDTH-1:0] stored_word;

  bsem_fifo_gate #(.MODE(MODE)) gate_i (
    .full      (full),
    .empty     (empty),
    .enq_en    (enq_en),
    .deq_en    (deq_en),
    .enq_rdy   (enq_rdy),
    .deq_rdy   (deq_rdy),
    .enq_fire  (enq_fire),
    .deq_fire  (deq_fire),
    .pass_thru (pass_thru)
  );

  // a passed-through word touches neither storage nor pointers
  assign wr = enq_fire && !pass_thru;
  assign rd = deq_fire && !pass_thru;

  bsem_fifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .rd    (rd),
    .head  (head),
    .tail  (tail),
    .occ   (occ),
    .full  (full),
    .empty (empty)
  );

  bsem_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
    .clk   (clk),
    .we    (wr),
    .waddr (tail),
    .wdata (enq_data),
    .raddr (head),
    .rdata (stored_word)
  );

  if (MODE == SEM_PASS) begin : g_pass_mux
    assign deq_data = empty ? enq_data : stored_word;
  end else begin : g_plain_out
    assign deq_data = stored_word;
  end

endmodule

// File: rtl/bsem_fifo_chk.sv
module bsem_fifo_chk
  import bsem_fifo_pkg::*;
#(
  parameter int        DEPTH = 4,
  parameter int        WIDTH = 8,
  parameter sem_mode_e MODE  = SEM_DRAIN,
  parameter int        CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_en,
  input logic             deq_en,
  input logic             enq_rdy,
  input logic             deq_rdy,
  input logic [WIDTH-1:0] enq_data,
  input logic [WIDTH-1:0] deq_data,
  input logic [CW-1:0]    occ,
  input logic             full,
  input logic             empty,
  input logic             enq_fire,
  input logic             deq_fire,
  input logic             pass_thru
);

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_mid_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && enq_en && deq_en) |-> (enq_fire && deq_fire));

  assert_mid_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && enq_fire && deq_fire) |=> (occ == $past(occ)));

  assert_strict_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SEM_STRICT && full) |-> !enq_rdy);

  assert_strict_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SEM_STRICT && empty) |-> !deq_rdy);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && enq_fire) |-> deq_fire);

  assert_drain_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SEM_DRAIN && full && deq_en) |-> enq_rdy);

  assert_drain_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && enq_fire && deq_fire) |=> full);

  assert_drain_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SEM_DRAIN && empty) |-> !deq_rdy);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && deq_fire) |-> (MODE == SEM_PASS && enq_fire));

  assert_pass_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |-> (deq_data == enq_data));

  assert_pass_unstored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |=> empty);

  assert_pass_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SEM_PASS && full) |-> !enq_rdy);

  assert_idle_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_fire && !deq_fire) |=> (occ == $past(occ)));

endmodule

bind bsem_fifo bsem_fifo_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .MODE(MODE), .CW(CW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_en    (enq_en),
  .deq_en    (deq_en),
  .enq_rdy   (enq_rdy),
  .deq_rdy   (deq_rdy),
  .enq_data  (enq_data),
  .deq_data  (deq_data),
  .occ       (occ),
  .full      (full),
  .empty     (empty),
  .enq_fire  (enq_fire),
  .deq_fire  (deq_fire),
  .pass_thru (pass_thru)
);

// File: tb/bsem_fifo_tb_top.sv
`timescale 1ns/1ps
module bsem_fifo_tb_top;
  import bsem_fifo_pkg::*;

  localparam int D = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_en = 1'b0;
  logic deq_en = 1'b0;
  logic [W-1:0] enq_data = '0;

  logic         enq_rdy_w  [3];
  logic         deq_rdy_w  [3];
  logic [W-1:0] deq_data_w [3];

  int tests = 0;
  int fails = 0;

  // behavioural model: one ring of words per mode
  logic [W-1:0] mbuf [3][D];
  int mhead [3];
  int mcnt  [3];

  always #2 clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    localparam sem_mode_e MD = sem_mode_e'(m);
    bsem_fifo #(.DEPTH(D), .WIDTH(W), .MODE(MD)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enq_en   (enq_en),
      .enq_data (enq_data),
      .enq_rdy  (enq_rdy_w[m]),
      .deq_en   (deq_en),
      .deq_data (deq_data_w[m]),
      .deq_rdy  (deq_rdy_w[m])
    );
  end

  task automatic chk(input string tag, input string what, input int m,
                     input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s mode%0d %s actual=%0d expected=%0d", tag, m, what, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic [W-1:0] d, input logic x);
    enq_en = e;
    enq_data = d;
    deq_en = x;
    #1;
    for (int m = 0; m < 3; m++) begin
      int s;
      bit isfull, isempty, er, dr, ef, df;
      string tg;
      int expd;
      s = mcnt[m];
      isfull = (s == D);
      isempty = (s == 0);
      er = (m == 1) ? (!isfull || x) : !isfull;
      dr = (m == 2) ? (!isempty || e) : !isempty;
      if (isempty) tg = (m == 0) ? "R4" : (m == 1) ? "R6" : "R7";
      else if (isfull) tg = (m == 0) ? "R4" : (m == 1) ? "R5" : "R8";
      else tg = "R3";
      chk((e && !er) ? "R9" : tg, "enq_rdy", m, int'(enq_rdy_w[m]), int'(er));
      chk((x && !dr) ? "R9" : tg, "deq_rdy", m, int'(deq_rdy_w[m]), int'(dr));
      ef = e && er;
      df = x && dr;
      if (df) begin
        expd = isempty ? int'(d) : int'(mbuf[m][mhead[m]]);
        chk(isempty ? "R7" : "R2", "deq_data", m, int'(deq_data_w[m]), expd);
      end
      if (!(df && isempty)) begin
        if (df) begin
          mhead[m] = (mhead[m] + 1) % D;
          mcnt[m] = mcnt[m] - 1;
        end
        if (ef) begin
          mbuf[m][(mhead[m] + mcnt[m]) % D] = d;
          mcnt[m] = mcnt[m] + 1;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      mhead[m] = 0;
      mcnt[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int m = 0; m < 3; m++) begin
      chk("R1", "enq_rdy after reset", m, int'(enq_rdy_w[m]), 1);
      chk("R1", "deq_rdy after reset", m, int'(deq_rdy_w[m]), 0);
    end
    @(negedge clk);
    // empty queue, write and read together: pass-through only in mode 2 (R7)
    drive(1'b1, 8'hA5, 1'b1);
    drive(1'b0, 8'h00, 1'b1);
    drive(1'b0, 8'h00, 1'b1);
    // fill to full, then stress the full boundary (R4, R5, R8)
    for (int i = 0; i < D + 1; i++) drive(1'b1, 8'(8'h10 + i), 1'b0);
    drive(1'b1, 8'h77, 1'b1);
    drive(1'b1, 8'h78, 1'b1);
    for (int i = 0; i < D + 1; i++) drive(1'b0, 8'h00, 1'b1);
    // phased traffic so every mode keeps hitting both boundaries
    for (int i = 0; i < 900; i++) begin
      int ph, pe, px;
      ph = (i / 30) % 3;
      pe = (ph == 0) ? 85 : (ph == 1) ? 20 : 55;
      px = (ph == 0) ? 25 : (ph == 1) ? 85 : 55;
      drive(($urandom % 100) < pe, 8'($urandom), ($urandom % 100) < px);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    tests++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule